// File: doc/BRIEF.md
# Serial PHY Management Master

This block is a register-driven master for the two-wire PHY management bus. Software programs a clock divider and an enable bit in a control word. It then writes one command word that holds a start flag, the transfer direction, a five-bit PHY address, a five-bit register address and sixteen data bits. The block sends a full clause-22 frame on the management clock and data pins. For a read, it releases the data line after the addresses and collects the PHY's answer.

When the frame completes, the block clears the start flag itself. Software polls that flag to see that the transfer is over. It then reads the command word back, which now holds the read data and a flag telling whether the PHY answered. The host interface is a single-cycle write strobe with a one-bit register select. Read data is combinational.

Top module: `phy_mgmt_master`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (idle flag set, enable clear, divider zero), the command word reads zero, and MDC and the data output enable are low.
- R2: While a frame runs, MDC has a period of max(divider,1)+1 input clock cycles. The divider sits in control bits 15:0 and enable in bit 30. Outside a frame MDC is held low.
- R3: A frame is 64 bits sent MSB first: 32 ones, start 01, opcode (01 write, 10 read), PHY address, register address, turnaround, then 16 data bits. A write sends turnaround 10 and the data from the command word. Command word fields: bit 31 start flag, bit 30 write(1)/read(0), bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data.
- R4: The data output changes only on a falling MDC edge and stays stable while MDC is high.
- R5: On a read, the output enable is high for the first 46 bits and low for both turnaround bits and all 16 data bits. On a write it is high for all 64 bits.
- R6: On a read, the data line is sampled on each rising MDC edge. The 16 data bits land in command bits 15:0, and bit 29 (acknowledge) is set when the second turnaround bit is sampled low.
- R7: A read that the PHY does not answer (second turnaround bit high) leaves bit 29 clear. A write always leaves bit 29 clear and keeps its data field.
- R8: The start flag stays set until the frame's last falling MDC edge and then clears. A command-word write while the flag is set has no effect.
- R9: A frame starts only while enable is set. A command written while enable is clear waits. Control bit 31 (idle) reads 1 exactly when enable is clear and no frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 command |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register |
| mdio_in | input | 1 | Sampled management data line |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data output enable |

## Verification
The hardest case to reach is a command-word write that lands while a frame is in flight. The bench makes it happen by writing a second, different command a few cycles after the first one starts. It then checks that the completed word still carries the first command. The other hard case is the acknowledge bit, which depends on a single sampled turnaround bit. A PHY model in the bench counts rising MDC edges and drives the line on falling edges. It drives the line low, with the data after it, only when a vector marks the PHY as answering. Every vector uses its own divider, so the period check and the sampling positions are exercised at several clock ratios, including the clamped zero divider.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int PRE_BITS   = 32;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TA_FIRST   = PRE_BITS + 4 + 2 * ADDR_W;   // first turnaround bit index
    localparam int DATA_FIRST = TA_FIRST + 2;

    localparam int GO_BIT   = 31;
    localparam int WR_BIT   = 30;
    localparam int ACK_BIT  = 29;
    localparam int REG_LSB  = 21;
    localparam int PHY_LSB  = 16;
    localparam int IDLE_BIT = 31;
    localparam int EN_BIT   = 30;

    typedef struct packed {
        logic              go;
        logic              wr;
        logic [ADDR_W-1:0] reg_a;
        logic [ADDR_W-1:0] phy_a;
        logic [DATA_W-1:0] data;
    } mgmt_cmd_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(mgmt_cmd_t c);
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] d;
        op = c.wr ? 2'b01 : 2'b10;
        ta = c.wr ? 2'b10 : 2'b11;
        d  = c.wr ? c.data : {DATA_W{1'b1}};
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy_a, c.reg_a, ta, d};
    endfunction
endpackage

// File: rtl/phy_mgmt_clkgen.sv
module phy_mgmt_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tk,
    output logic             fall_tk
);
    localparam logic [DIV_W:0]   ONE_X = 1;
    localparam logic [DIV_W-1:0] ONE_D = 1;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] d_eff;
    logic [DIV_W:0]   hi_start;

    // a zero divider is clamped so the clock keeps a low and a high phase
    assign d_eff    = (div == '0) ? ONE_D : div;
    assign hi_start = ({1'b0, d_eff} + ONE_X) >> 1;
    assign rise_tk  = run && ({1'b0, cnt} == hi_start - ONE_X);
    assign fall_tk  = run && (cnt == d_eff);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (fall_tk) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + ONE_D;
            if (rise_tk) mdc <= 1'b1;
        end
    end

    p_mdc_rest_low_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);
endmodule

// File: rtl/phy_mgmt_shifter.sv
module phy_mgmt_shifter
    import phy_mgmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  is_rd,
    input  logic                  rise_tk,
    input  logic                  fall_tk,
    input  logic                  mdio_in,
    output logic                  busy,
    output logic                  done,
    output logic                  mdio_out,
    output logic                  mdio_oe,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  ack
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_FIRST + 1);
    localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);
    localparam logic [IDX_W-1:0] ONE_I    = 1;

    logic [FRAME_BITS-1:0] sr;
    logic [IDX_W-1:0]      idx;
    logic                  rd_q;
    logic                  ta_smp;

    assign done     = busy && fall_tk && (idx == LAST_IDX);
    assign mdio_out = sr[FRAME_BITS-1];
    assign mdio_oe  = busy && (!rd_q || (idx < TA1_IDX));
    assign ack      = rd_q && !ta_smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '1;
            idx     <= '0;
            busy    <= 1'b0;
            rd_q    <= 1'b0;
            ta_smp  <= 1'b1;
            rd_data <= '0;
        end else if (start && !busy) begin
            sr     <= frame_in;
            idx    <= '0;
            busy   <= 1'b1;
            rd_q   <= is_rd;
            ta_smp <= 1'b1;
        end else if (busy) begin
            if (rise_tk) begin
                if (idx == TA2_IDX) ta_smp <= mdio_in;
                if (idx >= DAT_IDX) rd_data <= {rd_data[DATA_W-2:0], mdio_in};
            end
            if (fall_tk) begin
                if (idx == LAST_IDX) begin
                    busy <= 1'b0;
                    sr   <= '1;
                end else begin
                    idx <= idx + ONE_I;
                    sr  <= {sr[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    p_done_ends_frame_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    p_ack_only_read_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !rd_q) |-> !ack);
endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
    import phy_mgmt_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_sel,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        mdio_in,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe
);
    localparam int PAD_W = 30 - DIV_W;

    logic             ctrl_en;
    logic [DIV_W-1:0] ctrl_div;
    mgmt_cmd_t        cmd;
    logic             acc_ack;
    logic             frame_busy;
    logic             frame_done;
    logic             frame_start;
    logic             rise_tk;
    logic             fall_tk;
    logic             rx_ack;
    logic [DATA_W-1:0] rx_data;
    logic             idle_flag;

    assign frame_start = cmd.go && ctrl_en && !frame_busy;
    assign idle_flag   = !ctrl_en && !frame_busy;

    phy_mgmt_clkgen #(.DIV_W(DIV_W)) clk_i (
        .clk(clk), .rst(rst), .run(frame_busy), .div(ctrl_div),
        .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
    );

    phy_mgmt_shifter shf_i (
        .clk(clk), .rst(rst), .start(frame_start), .frame_in(build_frame(cmd)),
        .is_rd(!cmd.wr), .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_in(mdio_in),
        .busy(frame_busy), .done(frame_done), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .rd_data(rx_data), .ack(rx_ack)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en  <= 1'b0;
            ctrl_div <= '0;
            cmd      <= '0;
            acc_ack  <= 1'b0;
        end else begin
            if (bus_wr && !bus_sel) begin
                ctrl_en  <= bus_wdata[EN_BIT];
                ctrl_div <= bus_wdata[DIV_W-1:0];
            end
            if (bus_wr && bus_sel && !cmd.go) begin
                cmd.go    <= bus_wdata[GO_BIT];
                cmd.wr    <= bus_wdata[WR_BIT];
                cmd.reg_a <= bus_wdata[REG_LSB +: ADDR_W];
                cmd.phy_a <= bus_wdata[PHY_LSB +: ADDR_W];
                cmd.data  <= bus_wdata[DATA_W-1:0];
                acc_ack   <= 1'b0;
            end
            if (frame_done) begin
                cmd.go  <= 1'b0;
                acc_ack <= rx_ack;
                if (!cmd.wr) cmd.data <= rx_data;
            end
        end
    end

    always_comb begin
        if (bus_sel)
            bus_rdata = {cmd.go, cmd.wr, acc_ack, 3'b000, cmd.reg_a, cmd.phy_a, cmd.data};
        else
            bus_rdata = {idle_flag, ctrl_en, {PAD_W{1'b0}}, ctrl_div};
    end

    p_oe_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> frame_busy);
    p_go_held_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd.go && !frame_done) |=> cmd.go);
    p_start_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_busy) |-> $past(ctrl_en));
    p_out_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_out));
endmodule

// File: tb/phy_mgmt_master_tb.sv
module phy_mgmt_master_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdio_in = 1'b1;
    logic        mdc, mdio_out, mdio_oe;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rises = 0;
    int last_rise = 0;
    int last_period = 0;
    logic [63:0] cap = '0;
    logic [63:0] oecap = '0;
    logic        phy_resp = 1'b0;
    logic [15:0] phy_data = '0;

    phy_mgmt_master dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdio_in(mdio_in),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc = cyc + 1;

    // PHY model: capture on rising MDC, answer on falling MDC
    function automatic logic phy_bit(int k);
        if (!phy_resp) return 1'b1;
        if (k == 47) return 1'b0;
        if (k >= 48 && k < 64) return phy_data[63-k];
        return 1'b1;
    endfunction

    always @(posedge mdc) begin
        if (rises < 64) begin
            cap[63-rises]   = mdio_out;
            oecap[63-rises] = mdio_oe;
        end
        rises = rises + 1;
        last_period = cyc - last_rise;
        last_rise = cyc;
    end
    always @(negedge mdc) mdio_in = phy_bit(rises);

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] dat;
        logic        resp;
        logic [15:0] div;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 5'h01, 5'h00, 16'h1234, 1'b0, 16'd0},
        '{1'b0, 5'h03, 5'h02, 16'hBEEF, 1'b1, 16'd1},
        '{1'b0, 5'h1F, 5'h1F, 16'h0001, 1'b0, 16'd2},
        '{1'b1, 5'h10, 5'h0A, 16'hA5C3, 1'b0, 16'd3},
        '{1'b0, 5'h05, 5'h11, 16'h8000, 1'b1, 16'd4},
        '{1'b1, 5'h1E, 5'h15, 16'hFFFF, 1'b0, 16'd1}
    };

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(logic sel, logic [31:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic sel, output logic [31:0] d);
        @(negedge clk);
        bus_sel = sel;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] w;
        for (int i = 0; i < 4000; i++) begin
            bus_read(1'b1, w);
            if (!w[31]) return;
        end
        check("R8 go never cleared", 64'(w[31]), 64'd0);
    endtask

    function automatic logic [31:0] cmd_word(logic go, logic wr, logic [4:0] rg, logic [4:0] phy, logic [15:0] d);
        return {go, wr, 1'b0, 3'b000, rg, phy, d};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [63:0] exp_f;
        int d_eff;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        bus_read(1'b0, w); check("R1 control after reset", 64'(w), 64'h8000_0000);
        bus_read(1'b1, w); check("R1 command after reset", 64'(w), 64'h0);
        check("R1 mdc low", 64'(mdc), 64'd0);
        check("R1 oe low", 64'(mdio_oe), 64'd0);

        foreach (VECS[i]) begin
            vec_t v;
            v = VECS[i];
            bus_write(1'b0, {2'b01, 14'd0, v.div});
            bus_read(1'b0, w); check("R9 idle clear while enabled", 64'(w[31]), 64'd0);
            phy_resp = v.resp; phy_data = v.dat; rises = 0;
            bus_write(1'b1, cmd_word(1'b1, v.wr, v.rg, v.phy, v.dat));
            wait_done();
            bus_read(1'b1, w);
            exp_f = {32'hFFFF_FFFF, 2'b01, v.wr ? 2'b01 : 2'b10, v.phy, v.rg, 2'b10, v.dat};
            if (v.wr) begin
                check("R3 write frame bits", cap, exp_f);
                check("R5 write oe all bits", oecap, '1);
                check("R7 write word back", 64'(w), 64'(cmd_word(1'b0, 1'b1, v.rg, v.phy, v.dat)));
            end else begin
                check("R3 read frame header", 64'(cap[63:18]), 64'(exp_f[63:18]));
                check("R5 read oe release", oecap, {{46{1'b1}}, 18'd0});
                if (v.resp) begin
                    check("R6 read ack and data", 64'(w), 64'(cmd_word(1'b0, 1'b0, v.rg, v.phy, v.dat) | 32'h2000_0000));
                end else begin
                    check("R7 no answer ack clear", 64'(w[29]), 64'd0);
                end
            end
            check("R8 go cleared", 64'(w[31]), 64'd0);
            d_eff = (v.div == 0) ? 1 : int'(v.div);
            check("R2 mdc period", 64'(last_period), 64'(d_eff + 1));
            check("R2 rise count", 64'(rises), 64'd64);
            repeat (3) @(negedge clk);
            check("R2 mdc low after frame", 64'(mdc), 64'd0);
        end

        // R8 write while busy is ignored
        bus_write(1'b0, {2'b01, 14'd0, 16'd2});
        phy_resp = 1'b0; rises = 0;
        bus_write(1'b1, cmd_word(1'b1, 1'b1, 5'h07, 5'h09, 16'h5A5A));
        repeat (10) @(negedge clk);
        bus_write(1'b1, cmd_word(1'b1, 1'b0, 5'h1C, 5'h02, 16'h0F0F));
        wait_done();
        bus_read(1'b1, w);
        check("R8 busy write ignored", 64'(w), 64'(cmd_word(1'b0, 1'b1, 5'h07, 5'h09, 16'h5A5A)));
        check("R8 only one frame sent", 64'(rises), 64'd64);

        // R9 command held while disabled
        bus_write(1'b0, {2'b00, 14'd0, 16'd1});
        rises = 0;
        bus_write(1'b1, cmd_word(1'b1, 1'b1, 5'h03, 5'h04, 16'h00FF));
        repeat (40) @(negedge clk);
        bus_read(1'b1, w); check("R9 go pending while disabled", 64'(w[31]), 64'd1);
        check("R9 no mdc while disabled", 64'(rises), 64'd0);
        bus_read(1'b0, w); check("R9 idle set while disabled", 64'(w[31]), 64'd1);
        bus_write(1'b0, {2'b01, 14'd0, 16'd1});
        wait_done();
        check("R9 frame after enable", cap, {32'hFFFF_FFFF, 4'b0101, 5'h04, 5'h03, 2'b10, 16'h00FF});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule